// File: doc/BRIEF.md
# Cascadable serial configuration memory

This block is a one-bit-wide read-only store that streams a configuration bitstream into an FPGA, one bit per clock. An internal address counter selects the stored bit. The counter moves forward on each rising clock edge, but only while the device is selected and its output is enabled. The selected bit is driven onto a tri-state data line. The device releases the line whenever it is deselected, held in reset, or finished.

A single pin serves as both the reset input and the output-enable input. A parameter chooses which level of that pin means reset; the other level means the output is enabled. When the counter steps past the last stored bit, a sticky completion flag is set. The flag stops the counter and releases the data line. It also pulls the cascade enable output low, so the next device in a daisy chain takes over the shared data line. A registered standby output reports when the device is deselected. The bit array is loaded through a synchronous write port.

Top module: `serial_cfg_rom`

## Requirements
- R1: While reset is active, the address counter is held at zero, the completion flag is cleared, `dout_en` is 0 and `ce_out_n` is 1.
- R2: With `RST_ACTIVE_HIGH`=1, reset is active when `rst_oe` is 1. With `RST_ACTIVE_HIGH`=0, reset is active when `rst_oe` is 0. In both cases the other level enables the output.
- R3: After reset is released, stored bit 0 is on `dout` with `dout_en`=1. Each rising edge taken with `ce_n`=0 and the output enabled advances the counter by one. The bit at the new address is presented after that edge.
- R4: While `ce_n` is 1, the counter does not move and `dout_en` is 0.
- R5: `standby` equals the value `ce_n` had at the previous rising edge.
- R6: An advancing edge at address DEPTH-1 sets the completion flag. From then on the counter does not move, and `dout_en` stays 0 until reset.
- R7: `ce_out_n` is 0 exactly when `ce_n` is 0, the output is enabled and the completion flag is set. After completion it follows `ce_n`.
- R8: Only reset clears the completion flag. A pause on `ce_n` after completion does not re-enable `dout`.
- R9: A rising edge with `wr_en`=1 stores `wr_data` at `wr_addr`. The stored bit is played back when the counter reaches that address.
- R10: When the `ce_out_n` of one device drives the `ce_n` of a second device, the two bit streams come out back to back in order. The two devices never drive the shared line at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edges step the counter |
| rst_oe | input | 1 | Combined reset / output-enable, polarity set by `RST_ACTIVE_HIGH` |
| ce_n | input | 1 | Active-low chip enable |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | AW | Array write address |
| wr_data | input | 1 | Array write bit |
| dout | output | 1 | Serial data, high-impedance when not driving |
| dout_en | output | 1 | 1 while `dout` is driven |
| ce_out_n | output | 1 | Active-low enable for the next device in the chain |
| standby | output | 1 | Registered low-power indication |

## Verification
Two things can happen in the same edge: the terminal-count step that hands the line to the next device, and a change of `ce_n` or an arriving reset. The bench provokes this with random pauses and resets across long read-outs. It adds a directed case in which reset lands exactly on the terminal edge. Each cycle is judged against a stream-position model that predicts which device drives and which bit it drives. The model also checks that the two drivers are never enabled together.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
  // Decode the combined pin: 1 means reset is in force.
  function automatic logic rst_hit(input logic pin, input bit act_high);
    return act_high ? pin : ~pin;
  endfunction
endpackage

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          reset_act,
  input  logic          step_en,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] addr_nx,
  output logic          done_q
);
  localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

  logic done_nx;

  always_comb begin
    addr_nx = addr_q;
    done_nx = done_q;
    if (reset_act) begin
      addr_nx = '0;
      done_nx = 1'b0;
    end else if (step_en && !done_q) begin
      if (addr_q == TC) done_nx = 1'b1;
      else              addr_nx = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_nx;
    done_q <= done_nx;
  end
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic mem [DEPTH];

  // Synchronous write and registered read, so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_bit <= mem[rd_addr];
  end
endmodule

// File: rtl/cfg_chain_ctl.sv
module cfg_chain_ctl (
  input  logic clk,
  input  logic reset_act,
  input  logic ce_n,
  input  logic done,
  input  logic rd_bit,
  output logic dout,
  output logic dout_en,
  output logic ce_out_n,
  output logic standby
);
  logic sel;

  assign sel      = !ce_n && !reset_act;
  assign dout_en  = sel && !done;
  assign dout     = dout_en ? rd_bit : 1'bz;
  assign ce_out_n = !(sel && done);

  always_ff @(posedge clk) standby <= ce_n;
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
  parameter int DEPTH = 64,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_oe,
  input  logic          ce_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  output logic          dout,
  output logic          dout_en,
  output logic          ce_out_n,
  output logic          standby
);
  import cfg_rom_pkg::*;

  logic          reset_act;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_nx;
  logic          done_q;
  logic          rd_bit;

  assign reset_act = rst_hit(rst_oe, RST_ACTIVE_HIGH);

  cfg_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk(clk), .reset_act(reset_act), .step_en(!ce_n),
    .addr_q(addr_q), .addr_nx(addr_nx), .done_q(done_q)
  );

  cfg_bit_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr_nx), .rd_bit(rd_bit)
  );

  cfg_chain_ctl u_chain (
    .clk(clk), .reset_act(reset_act), .ce_n(ce_n), .done(done_q),
    .rd_bit(rd_bit), .dout(dout), .dout_en(dout_en),
    .ce_out_n(ce_out_n), .standby(standby)
  );
endmodule

// File: rtl/serial_cfg_rom_chk.sv
module serial_cfg_rom_chk #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          reset_act,
  input logic          ce_n,
  input logic [AW-1:0] addr,
  input logic          done,
  input logic          dout_en,
  input logic          ce_out_n,
  input logic          standby
);
  localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

  // R1
  always_comb if (reset_act === 1'b1) rst_quiet_chk: assert (!dout_en && ce_out_n);

  // R7
  always_comb if (!reset_act) no_dual_drive_chk: assert (!(dout_en && !ce_out_n));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (reset_act)
    (!ce_n && !done && addr != TC) |=> addr == $past(addr) + 1'b1);

  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (reset_act)
    ce_n |=> $stable(addr) && !($past(dout_en) && $past(ce_n)));

  // R5
  standby_chk: assert property (@(posedge clk) disable iff (reset_act)
    1'b1 |=> standby == $past(ce_n));

  // R6
  tc_set_chk: assert property (@(posedge clk) disable iff (reset_act)
    (!ce_n && addr == TC) |=> done);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (reset_act)
    done |=> done && $stable(addr) && !dout_en);
endmodule

bind serial_cfg_rom serial_cfg_rom_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .reset_act(reset_act), .ce_n(ce_n), .addr(addr_q),
  .done(done_q), .dout_en(dout_en), .ce_out_n(ce_out_n), .standby(standby)
);

// File: tb/serial_cfg_rom_test.sv
`timescale 1ns/1ps
module serial_cfg_rom_test;
  localparam int DA = 64;
  localparam int DC = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, ce_n = 1'b1, wr_en = 1'b0, wr_en_c = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [3:0] wr_addr_c = '0;
  logic wa = 1'b0, wb = 1'b0, wc = 1'b0;
  wire  da, db, dc;
  logic ea, eb, ec, coa, cob, coc, sa, sb, sc;

  serial_cfg_rom #(.DEPTH(DA)) uut (
    .clk(clk), .rst_oe(rst), .ce_n(ce_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wa), .dout(da), .dout_en(ea), .ce_out_n(coa), .standby(sa));
  serial_cfg_rom #(.DEPTH(DA)) uut_b (
    .clk(clk), .rst_oe(rst), .ce_n(coa), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wb), .dout(db), .dout_en(eb), .ce_out_n(cob), .standby(sb));
  serial_cfg_rom #(.DEPTH(DC), .RST_ACTIVE_HIGH(1'b0)) uut_c (
    .clk(clk), .rst_oe(~rst), .ce_n(ce_n), .wr_en(wr_en_c), .wr_addr(wr_addr_c),
    .wr_data(wc), .dout(dc), .dout_en(ec), .ce_out_n(coc), .standby(sc));

  bit ma [DA];
  bit mb [DA];
  bit mc [DC];
  int pos = 0, posc = 0;
  bit prev_ce = 1'b1, prev_coa = 1'b1, prev_ok = 1'b0;
  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;

  task automatic cmp(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (pos=%0d t=%0t)", req, act, exp, pos, $time);
    end
  endtask

  function automatic bit exp_en_a(bit r, bit c, int p);
    return !r && !c && p < DA;
  endfunction

  task automatic cyc(bit nrst, bit nce);
    bit xa, xb, xc;
    @(negedge clk);
    rst = nrst; ce_n = nce;
    #1;
    xa = exp_en_a(rst, ce_n, pos);
    xb = !rst && !ce_n && pos >= DA && pos < 2*DA;
    xc = !rst && !ce_n && posc < DC;
    cmp("R1/R4/R6 A drive", ea, xa);
    cmp("R10 B drive", eb, xb);
    if (xa) cmp("R3/R9 A bit", da, ma[pos]);
    if (xb) cmp("R10 B bit", db, mb[pos-DA]);
    cmp("R10 single driver", ea & eb, 0);
    cmp("R7 A cascade", coa, !(!rst && !ce_n && pos >= DA));
    cmp("R7/R8 B cascade", cob, !(!rst && !ce_n && pos >= 2*DA));
    cmp("R2 C drive", ec, xc);
    if (xc) cmp("R2 C bit", dc, mc[posc]);
    cmp("R2 C cascade", coc, !(!rst && !ce_n && posc >= DC));
    if (prev_ok) begin
      cmp("R5 A standby", sa, prev_ce);
      cmp("R5 B standby", sb, prev_coa);
    end
    if (rst) begin
      pos = 0; posc = 0;
    end else if (!ce_n) begin
      if (pos < 2*DA) pos++;
      if (posc < DC) posc++;
    end
    prev_ce = ce_n; prev_coa = coa; prev_ok = 1'b1;
  endtask

  // R9: new contents through the write port, under reset
  task automatic load();
    for (int i = 0; i < DA; i++) begin
      @(negedge clk);
      rst = 1'b1; ce_n = 1'b1;
      wr_en = 1'b1; wr_addr = 6'(i);
      wa = 1'($urandom); wb = 1'($urandom);
      ma[i] = wa; mb[i] = wb;
      wr_en_c = (i < DC);
      wr_addr_c = 4'(i % DC);
      wc = 1'($urandom);
      if (i < DC) mc[i] = wc;
    end
    @(negedge clk);
    wr_en = 1'b0; wr_en_c = 1'b0;
    pos = 0; posc = 0; prev_ce = 1'b1; prev_coa = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int e = 0; e < 6; e++) begin
      load();
      cyc(1'b1, 1'b1);
      cyc(1'b1, 1'b0);   // R1: reset with chip enabled stays quiet
      if (e == 0) begin
        for (int k = 0; k < 2*DA + 8; k++) cyc(1'b0, 1'b0);
      end else if (e == 1) begin
        // R8: pauses after completion of both devices
        for (int k = 0; k < DA + 3; k++) cyc(1'b0, 1'b0);
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1);
        for (int k = 0; k < DA + 6; k++) cyc(1'b0, 1'b0);
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0);
      end else if (e == 2) begin
        // R6/R1: reset lands on the terminal edge of the first device
        for (int k = 0; k < DA - 1; k++) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        for (int k = 0; k < 20; k++) cyc(1'b0, 1'b0);
      end else begin
        for (int k = 0; k < 260; k++)
          cyc(($urandom % 150) == 0, ($urandom % 4) == 0);
      end
    end
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule